// File: doc/BRIEF.md
# Systolic Symmetric FIR Filter

This block filters a stream of signed samples with a linear-phase FIR whose impulse response is symmetric. Since taps j and N-1-j carry the same weight, the two samples that meet that weight are added together first and multiplied once. An N-tap filter therefore needs only ceil(N/2) multiplier cells. The cells form a chain. Each cell holds its own weight in a local register, registers its operands and its product, and passes a registered partial sum on to the next cell. No adder tree appears anywhere, and the critical path is one add or one multiply at any tap count.

Samples arrive one per cycle with a valid flag. A cycle with the flag low counts as a zero sample, so the output stream stays in step with the input cycle by cycle. Weights are written one at a time through an indexed write port, and the filter keeps running while they are written. The tap count and all datapath widths are parameters. The defaults give the narrow precision set (17-bit samples, 18-bit weights, 44-bit sums). The package also carries the wide set (25/27/64).

Top module: `fir_systolic`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `outValid` and `outSample` are 0. Every weight register is cleared to 0, so samples sent before any weight write give a zero output.
- R2: With K = ceil(N/2) cells holding weights w[0..K-1], the impulse response is h[j] = w[j] for j < K and h[N-1-j] = w[j]. In output cycle t, `outSample` equals the exact signed sum over j of h[j]·x(t-K-3-j), where x(c) is the sample presented in input cycle c.
- R3: `outValid` in cycle t equals `inValid` in cycle t-(K+3). The same cycle carries the h[0] term of that sample.
- R4: A cycle with `inValid` low enters the filter as a zero sample, whatever `inSample` holds.
- R5: For odd N, the centre weight w[K-1] multiplies the middle sample once, with no pre-add, so that tap contributes w[K-1]·x and not 2·w[K-1]·x.
- R6: A cycle with `coefWe` high and `coefIdx` < K loads the signed `coefData` into cell `coefIdx`, and the multiply uses it from the next cycle. All other cells keep their weights.
- R7: A write whose `coefIdx` is K or above changes no weight.
- R8: Weight writes do not stall, flush or delay the sample stream. Output validity and the terms formed from unchanged weights are unaffected by a write.
- R9: Full-scale operands (most negative sample and most negative weight on every tap) produce the exact result, with no wrap in the pre-add, the product or the sum chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample on `inSample` is real this cycle |
| inSample | input | SAMPLE_W | Signed input sample |
| coefWe | input | 1 | Weight write strobe |
| coefIdx | input | IDX_W = clog2(K)+1 | Cell index for the write |
| coefData | input | COEF_W | Signed weight value |
| outValid | output | 1 | `outSample` belongs to a valid input |
| outSample | output | ACC_W | Signed filter output |

## Verification
The hardest case to reach from the ports is a weight write landing while products are still travelling down the sum chain. A write that really changes a weight mid-stream produces outputs that mix old and new weights. The bench therefore puts real changes only in quiet gaps, and drives same-value and out-of-range writes into the live pseudo-random stream, where any disturbance would show at once. Invalid cycles carry non-zero garbage on the sample bus, which exercises the zero-stuffing. A sweep over a grid of weight sets runs impulses through an odd-length and an even-length instance side by side, so the centre-tap handling and the mirror pairing are both compared against the arithmetic sum.

// File: rtl/fir_systolic_pkg.sv
package fir_systolic_pkg;

  // Precision presets for the sample, weight and sum widths
  localparam int NARROW_SAMPLE_W = 17;
  localparam int NARROW_COEF_W   = 18;
  localparam int NARROW_ACC_W    = 44;
  localparam int WIDE_SAMPLE_W   = 25;
  localparam int WIDE_COEF_W     = 27;
  localparam int WIDE_ACC_W      = 64;

  // Structural limits
  localparam int MAX_TAPS = 256;
  localparam int SEL_W    = 8;

  // Fixed register stages in front of and inside each cell, excluding the sum chain
  localparam int PIPE_STAGES = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic             sampleEn;
    logic             coefLoadEn;
    logic [SEL_W-1:0] coefSel;
  } firCtl_t;

  function automatic int cellCount(input int taps);
    return (taps + 1) / 2;
  endfunction

endpackage

// File: rtl/fir_systolic_cell.sv
module fir_systolic_cell
  import fir_systolic_pkg::*;
#(
  parameter int SAMPLE_W = NARROW_SAMPLE_W,
  parameter int COEF_W   = NARROW_COEF_W,
  parameter int ACC_W    = NARROW_ACC_W,
  parameter bit CENTRE   = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       loadEn,
  input  logic signed [COEF_W-1:0]   coefData,
  input  logic signed [SAMPLE_W-1:0] nearSample,
  input  logic signed [SAMPLE_W-1:0] farSample,
  input  logic signed [ACC_W-1:0]    sumIn,
  output logic signed [ACC_W-1:0]    sumOut
);

  localparam int PRE_W  = SAMPLE_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;

  logic signed [COEF_W-1:0]   coefReg;
  logic signed [SAMPLE_W-1:0] farOp;
  logic signed [PRE_W-1:0]    preReg;
  logic signed [PROD_W-1:0]   prodReg;
  logic signed [ACC_W-1:0]    prodExt;

  // A centre cell sees a single operand; a pair cell folds the mirror sample in
  generate
    if (CENTRE) begin : g_single
      assign farOp = '0;
    end else begin : g_pair
      assign farOp = farSample;
    end
  endgenerate

  assign prodExt = ACC_W'(prodReg);

  always_ff @(posedge clk) begin
    if (rst) begin
      coefReg <= '0;
      preReg  <= '0;
      prodReg <= '0;
      sumOut  <= '0;
    end else begin
      if (loadEn) coefReg <= coefData;
      preReg  <= PRE_W'(nearSample) + PRE_W'(farOp);
      prodReg <= coefReg * preReg;
      sumOut  <= sumIn + prodExt;
    end
  end

  // R6
  coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> $stable(coefReg));

  // R9
  sum_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (sumIn[ACC_W-1] == prodExt[ACC_W-1]) |=> (sumOut[ACC_W-1] == $past(sumIn[ACC_W-1])));

endmodule

// File: rtl/fir_systolic_dp.sv
module fir_systolic_dp
  import fir_systolic_pkg::*;
#(
  parameter int NUM_TAPS = 7,
  parameter int SAMPLE_W = NARROW_SAMPLE_W,
  parameter int COEF_W   = NARROW_COEF_W,
  parameter int ACC_W    = NARROW_ACC_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  firCtl_t                    ctl,
  input  logic signed [SAMPLE_W-1:0] inSample,
  input  logic signed [COEF_W-1:0]   coefData,
  output logic signed [ACC_W-1:0]    outSample
);

  localparam int NUM_CELLS  = cellCount(NUM_TAPS);
  localparam bit HAS_CENTRE = (NUM_TAPS % 2) == 1;

  // Forward sample line: cell i reads tap 2i, the mirror operand is the line's end
  logic signed [SAMPLE_W-1:0] xChain [NUM_TAPS];
  logic signed [ACC_W-1:0]    sumChain [NUM_CELLS+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NUM_TAPS; j++) xChain[j] <= '0;
    end else begin
      xChain[0] <= ctl.sampleEn ? inSample : '0;
      for (int j = 1; j < NUM_TAPS; j++) xChain[j] <= xChain[j-1];
    end
  end

  assign sumChain[0] = '0;

  generate
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      logic cellLoad;
      assign cellLoad = ctl.coefLoadEn && (ctl.coefSel == SEL_W'(i));

      fir_systolic_cell #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .ACC_W    (ACC_W),
        .CENTRE   (HAS_CENTRE && (i == NUM_CELLS - 1))
      ) u_cell (
        .clk        (clk),
        .rst        (rst),
        .loadEn     (cellLoad),
        .coefData   (coefData),
        .nearSample (xChain[2*i]),
        .farSample  (xChain[NUM_TAPS-1]),
        .sumIn      (sumChain[i]),
        .sumOut     (sumChain[i+1])
      );
    end
  endgenerate

  assign outSample = sumChain[NUM_CELLS];

  // R7
  sel_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.coefLoadEn |-> (ctl.coefSel < SEL_W'(NUM_CELLS)));

  // R4
  bubble_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.sampleEn |=> (xChain[0] == '0));

endmodule

// File: rtl/fir_systolic_ctrl.sv
module fir_systolic_ctrl
  import fir_systolic_pkg::*;
#(
  parameter int NUM_TAPS = 7,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             coefWe,
  input  logic [IDX_W-1:0] coefIdx,
  output firCtl_t          ctl,
  output logic             outValid
);

  localparam int NUM_CELLS = cellCount(NUM_TAPS);
  localparam int LAT       = NUM_CELLS + PIPE_STAGES;

  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LAT-2:0], inValid};
  end

  assign outValid       = validPipe[LAT-1];
  assign ctl.sampleEn   = inValid;
  assign ctl.coefLoadEn = coefWe && (int'(coefIdx) < NUM_CELLS);
  assign ctl.coefSel    = SEL_W'(coefIdx);

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    validPipe[0] |=> (validPipe[1] == 1'b1));

endmodule

// File: rtl/fir_systolic.sv
module fir_systolic
  import fir_systolic_pkg::*;
#(
  parameter int NUM_TAPS = 7,
  parameter int SAMPLE_W = NARROW_SAMPLE_W,
  parameter int COEF_W   = NARROW_COEF_W,
  parameter int ACC_W    = NARROW_ACC_W,
  localparam int IDX_W   = $clog2(cellCount(NUM_TAPS)) + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inSample,
  input  logic                       coefWe,
  input  logic [IDX_W-1:0]           coefIdx,
  input  logic signed [COEF_W-1:0]   coefData,
  output logic                       outValid,
  output logic signed [ACC_W-1:0]    outSample
);

  firCtl_t ctlBus;

  fir_systolic_ctrl #(
    .NUM_TAPS (NUM_TAPS),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .coefWe   (coefWe),
    .coefIdx  (coefIdx),
    .ctl      (ctlBus),
    .outValid (outValid)
  );

  fir_systolic_dp #(
    .NUM_TAPS (NUM_TAPS),
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .ACC_W    (ACC_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctlBus),
    .inSample  (inSample),
    .coefData  (coefData),
    .outSample (outSample)
  );

  // R8
  write_keeps_stream_chk: assert property (@(posedge clk) disable iff (rst)
    coefWe |-> (ctlBus.sampleEn == inValid));

endmodule

// File: tb/fir_systolic_tb.sv
`timescale 1ns/1ps
module fir_systolic_tb;

  localparam int SW   = 17;
  localparam int CW   = 18;
  localparam int AW   = 44;
  localparam int NA   = 5;
  localparam int NB   = 6;
  localparam int K    = 3;
  localparam int LAT  = K + 3;
  localparam int IW   = 3;
  localparam int HIST = 8192;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst = 1'b1;
  logic                 inValid = 1'b0;
  logic signed [SW-1:0] inSample = '0;
  logic                 coefWe = 1'b0;
  logic [IW-1:0]        coefIdx = '0;
  logic signed [CW-1:0] coefData = '0;
  logic                 vA, vB;
  logic signed [AW-1:0] outA, outB;

  int     checks = 0;
  int     errors = 0;
  int     cyc = 0;
  bit     finished = 0;
  longint xHist [HIST];
  bit     vHist [HIST];
  longint coefM [K];
  logic [15:0] lfsr = 16'hACE1;

  fir_systolic #(.NUM_TAPS(NA), .SAMPLE_W(SW), .COEF_W(CW), .ACC_W(AW)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample), .coefWe(coefWe),
    .coefIdx(coefIdx), .coefData(coefData), .outValid(vA), .outSample(outA));

  fir_systolic #(.NUM_TAPS(NB), .SAMPLE_W(SW), .COEF_W(CW), .ACC_W(AW)) u_dutEven (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample), .coefWe(coefWe),
    .coefIdx(coefIdx), .coefData(coefData), .outValid(vB), .outSample(outB));

  function automatic longint refY(input int t, input int n);
    longint acc = 0;
    for (int j = 0; j < n; j++) begin
      int c = t - LAT - j;
      int k = (j < K) ? j : n - 1 - j;
      if (c >= 0) acc += coefM[k] * xHist[c];
    end
    return acc;
  endfunction

  task automatic cmp(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic checkOut(input string tag);
    bit ev = (cyc >= LAT) ? vHist[cyc-LAT] : 1'b0;
    cmp({tag, " R3 valid odd"},  longint'(vA), longint'(ev));
    cmp({tag, " R3 valid even"}, longint'(vB), longint'(ev));
    cmp({tag, " odd"},  longint'(outA), refY(cyc, NA));
    cmp({tag, " even"}, longint'(outB), refY(cyc, NB));
  endtask

  task automatic step(input bit v, input longint s, input bit we, input int idx,
                      input longint cd, input string tag);
    @(negedge clk);
    checkOut(tag);
    inValid  = v;
    inSample = SW'(s);
    coefWe   = we;
    coefIdx  = IW'(idx);
    coefData = CW'(cd);
    xHist[cyc] = v ? s : 0;
    vHist[cyc] = v;
    if (we && idx < K) coefM[idx] = cd;
    cyc++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 0, tag);
  endtask

  task automatic setCoefs(input longint c0, input longint c1, input longint c2, input string tag);
    step(1'b0, 0, 1'b1, 0, c0, tag);
    step(1'b0, 0, 1'b1, 1, c1, tag);
    step(1'b0, 0, 1'b1, 2, c2, tag);
  endtask

  function automatic longint lfsrSample();
    return longint'($signed({lfsr[0], lfsr}));
  endfunction

  task automatic advLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d actual running expected done", cyc);
    summary();
  end

  initial begin
    for (int i = 0; i < K; i++) coefM[i] = 0;
    // R1: outputs held at zero while reset is asserted
    repeat (3) @(negedge clk);
    cmp("R1 reset valid odd",  longint'(vA),   0);
    cmp("R1 reset sample odd", longint'(outA), 0);
    cmp("R1 reset valid even", longint'(vB),   0);
    cmp("R1 reset sample even", longint'(outB), 0);
    rst = 1'b0;
    xHist[0] = 0; vHist[0] = 0; cyc = 1;

    // R1: weights come up cleared, so a real impulse yields zero
    step(1'b1, 1000, 1'b0, 0, 0, "R1 cleared weights");
    idle(14, "R1 cleared weights");

    // R6: load weights, then an impulse reads them back; R5 centre counted once
    setCoefs(3, -7, 11, "R6 load");
    idle(12, "R6 settle");
    step(1'b1, 1, 1'b0, 0, 0, "R2 R5 impulse");
    idle(14, "R2 R5 impulse");
    step(1'b1, -2, 1'b0, 0, 0, "R2 neg impulse");
    step(1'b1, 5, 1'b0, 0, 0, "R2 back to back");
    idle(14, "R2 impulse tail");

    // R2 R4: pseudo-random stream with gaps carrying garbage
    for (int i = 0; i < 400; i++) begin
      advLfsr();
      step(lfsr[3] | lfsr[7], lfsrSample(), 1'b0, 0, 0, "R2 R4 stream");
    end

    // R7 R8: same-value rewrites and out-of-range writes inside the live stream
    for (int i = 0; i < 120; i++) begin
      bit we = (i % 3) == 0;
      int idx = (i % 2 == 0) ? (K + (i % 5) % (8 - K)) : 1;
      longint cd = (idx == 1) ? -7 : 40000;
      advLfsr();
      step(lfsr[5], lfsrSample(), we, idx, cd, "R7 R8 live writes");
    end
    idle(12, "R8 drain");

    // R9: full-scale operands
    setCoefs(-131072, -131072, -131072, "R9 load min");
    idle(12, "R9 settle");
    for (int i = 0; i < 20; i++) step(1'b1, -65536, 1'b0, 0, 0, "R9 min samples");
    for (int i = 0; i < 20; i++) step(1'b1, 65535, 1'b0, 0, 0, "R9 max samples");
    idle(14, "R9 drain");
    setCoefs(131071, -131072, 131071, "R9 load mixed");
    idle(12, "R9 settle");
    for (int i = 0; i < 20; i++) step(1'b1, (i % 2 == 0) ? -65536 : 65535, 1'b0, 0, 0, "R9 alternating");
    idle(14, "R9 drain");

    // R6 R2 R5: grid of weight sets, impulse and a short burst for each
    for (int a = -2; a <= 2; a++)
      for (int b = -2; b <= 2; b++)
        for (int c = -2; c <= 2; c++) begin
          setCoefs(a * 1000 + 1, b * 977, c * 1013 - 3, "R6 grid load");
          idle(2, "R6 grid settle");
          step(1'b1, 321, 1'b0, 0, 0, "R2 R5 grid impulse");
          step(1'b1, -65536, 1'b0, 0, 0, "R2 R5 grid burst");
          step(1'b0, 777, 1'b0, 0, 0, "R4 grid gap");
          step(1'b1, 65535, 1'b0, 0, 0, "R2 R5 grid burst");
          idle(13, "R2 grid tail");
        end

    summary();
  end

endmodule